// File: doc/BRIEF.md
# Display Link Training Controller

This block is the source-side sequencer that brings a serial display link with one or more lanes (two by default) into service. It talks to the sink's byte-addressed configuration space through an abstract register port. The port carries a request, a direction, an address, a byte count and up to six data bytes, and the sink answers with a one-cycle done strobe. The block first programs the link rate and lane count. It then runs a clock-recovery phase and a channel-equalization phase. In both phases it polls the sink's lane status and follows the sink's per-lane requests for voltage swing and pre-emphasis.

When a phase cannot finish, the block steps down from the higher rate to the lowest rate and starts over with fresh drive settings. If the lowest rate also fails, the block stops and reports failure. A programmable wait separates every pattern or drive write from the next status read. The result comes out as a one-cycle pass or fail pulse. The rate code and lane count that were used stay on the outputs until the next start.

Top module: `link_train_ctrl`

## Requirements
- R1: A start accepted in idle first writes two bytes at address 0x100. The first byte is the rate code, 0x0A when `high_rate` is 1 and 0x06 otherwise. The second byte is 0x80 OR the lane count. A `lane_sel` of 0 means one lane, and a value above the lane maximum means the maximum.
- R2: Clock recovery begins with a write at 0x102 of 1+lanes bytes. The first byte is 0x21 and one drive byte per active lane follows it. All drive bytes are zero at the start of every rate attempt.
- R3: Every poll reads 6 bytes at 0x202. Byte 0 holds one status nibble per lane, lane 0 in the low nibble. In that nibble bit 0 is clock recovered, bit 1 is equalized and bit 2 is symbol locked. Byte 2 bit 0 is inter-lane alignment. Request and address stay stable until done.
- R4: When every active lane shows bit 0, the block writes 0x23 at 0x102 followed by the current drive bytes.
- R5: Adjust requests sit in byte 4, lane 0 in the low nibble, with swing in nibble bits 1:0 and pre-emphasis in bits 3:2. The block writes them at 0x103 as one byte per active lane, with swing in bits 1:0 and pre-emphasis in bits 4:3. A request byte of 0x44 therefore gives drive bytes 0x08.
- R6: A drive byte whose swing is 3 has bit 2 set, and a drive byte whose pre-emphasis is 3 has bit 5 set. A request nibble of 0xF gives 0x3F and a nibble of 0xC gives 0x38.
- R7: Training passes when every active lane nibble is 0x7 and the alignment bit is set. The block then writes the single byte 0x00 at 0x102 and pulses `train_done`. A 0x7 nibble without alignment counts as a failed equalization poll.
- R8: A failed equalization poll that follows the fifth equalization adjustment write triggers the rate fallback.
- R9: An equalization poll in which an active lane has lost clock recovery triggers the rate fallback.
- R10: Clock recovery triggers the fallback in two cases. The first is a failing poll while an active lane is already at swing 3. The second is the fifth consecutive failing poll whose requested swings equal the current ones.
- R11: A fallback at rate 0x0A restarts at 0x06 with the 0x100 write and zeroed drive bytes. A fallback at 0x06 writes 0x00 at 0x102 and pulses `train_fail`.
- R12: After reset the request, pulses and rate outputs are zero. `train_done` and `train_fail` are single-cycle and never coincide. Rate and lanes hold their values after the pulse.
- R13: A poll that passes its phase wins over any retry or abort limit reached on the same poll.
- R14: At least `wait_cycles` clock cycles pass between the done of a pattern or drive write and the next status read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training; sampled in idle |
| high_rate | input | 1 | 1: begin at rate 0x0A, 0: begin at 0x06 |
| lane_sel | input | LCW (2) | Requested lane count |
| wait_cycles | input | WAIT_W (16) | Cycles between a write and the next poll |
| bus_req | output | 1 | Register access request, held until done |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W (12) | Sink register address |
| bus_len | output | 3 | Byte count |
| bus_wdata | output | 48 | Write bytes, byte k in bits 8k+7:8k |
| bus_done | input | 1 | Access complete, one cycle |
| bus_rdata | input | 48 | Read bytes, valid with done |
| train_done | output | 1 | Training passed pulse |
| train_fail | output | 1 | Training failed pulse |
| link_rate | output | 8 | Rate code in use or last used |
| link_lanes | output | LCW (2) | Lane count in use |

## Verification
One poll can reach its phase goal and a give-up limit at the same time. In equalization this happens on the sixth poll after five adjustments. In clock recovery it happens when a lane already sits at swing 3. The bench feeds a passing status on exactly that poll: a full 0x77 with alignment for equalization, and 0x11 at swing 3 for clock recovery. It then judges the outcome from the write log. The expected log shows the next pattern or the end write and no 0x100 rewrite, and the final rate is still the starting rate.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

    localparam logic [7:0]  RATE_HI   = 8'h0A;
    localparam logic [7:0]  RATE_LO   = 8'h06;
    localparam logic [11:0] A_LINKCFG = 12'h100;
    localparam logic [11:0] A_PATTERN = 12'h102;
    localparam logic [11:0] A_DRIVE   = 12'h103;
    localparam logic [11:0] A_STATUS  = 12'h202;
    localparam logic [7:0]  PAT_CR    = 8'h21;
    localparam logic [7:0]  PAT_EQ    = 8'h23;
    localparam logic [7:0]  PAT_OFF   = 8'h00;
    localparam logic [1:0]  LVL_TOP   = 2'd3;
    localparam int          POLL_LEN  = 6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CFG,
        S_TP1,
        S_CR_WAIT,
        S_CR_POLL,
        S_CR_ADJ,
        S_TP3,
        S_EQ_WAIT,
        S_EQ_POLL,
        S_EQ_ADJ,
        S_FALL,
        S_END
    } ltc_state_e;

endpackage

// File: rtl/ltc_delay.sv
module ltc_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] span,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = span;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ltc_status_eval.sv
module ltc_status_eval #(
    parameter int MAX_LANES = 2,
    parameter int DW        = 48
) (
    input  logic [DW-1:0]        rdata,
    input  logic [MAX_LANES-1:0] lane_en,
    output logic                 cr_all,
    output logic                 eq_all
);
    logic [MAX_LANES-1:0] cr_ok, full_ok;
    logic                 aligned;

    assign aligned = rdata[16];

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        localparam int SB = 8 * (i / 2) + 4 * (i % 2);
        logic [3:0] nib;
        assign nib        = rdata[SB +: 4];
        assign cr_ok[i]   = nib[0] | ~lane_en[i];
        assign full_ok[i] = (nib[2:0] == 3'b111) | ~lane_en[i];
    end

    assign cr_all = &cr_ok;
    assign eq_all = (&full_ok) & aligned;

endmodule

// File: rtl/ltc_lane_drive.sv
module ltc_lane_drive #(
    parameter int MAX_LANES = 2,
    parameter int DW        = 48
) (
    input  logic [DW-1:0]                rdata,
    output logic [MAX_LANES-1:0][7:0]    req_set,
    output logic [MAX_LANES-1:0][1:0]    req_swing
);
    import ltc_pkg::*;

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        localparam int AB = 8 * (4 + i / 2) + 4 * (i % 2);
        logic [1:0] sw, pe;
        assign sw           = rdata[AB +: 2];
        assign pe           = rdata[AB + 2 +: 2];
        assign req_swing[i] = sw;
        assign req_set[i]   = {2'b00, (pe == LVL_TOP), pe, (sw == LVL_TOP), sw};
    end

endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl #(
    parameter int MAX_LANES   = 2,
    parameter int ADDR_W      = 12,
    parameter int WAIT_W      = 16,
    parameter int EQ_LOOPS    = 5,
    parameter int CR_SAME_MAX = 5,
    localparam int LCW = $clog2(MAX_LANES + 1),
    localparam int DW  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              high_rate,
    input  logic [LCW-1:0]    lane_sel,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_len,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_done,
    input  logic [DW-1:0]     bus_rdata,
    output logic              train_done,
    output logic              train_fail,
    output logic [7:0]        link_rate,
    output logic [LCW-1:0]    link_lanes
);
    import ltc_pkg::*;

    localparam int EQW = $clog2(EQ_LOOPS + 1);
    localparam int SMW = $clog2(CR_SAME_MAX + 1);

    typedef struct packed {
        ltc_state_e                st;
        logic                      req;
        logic [7:0]                rate;
        logic [LCW-1:0]            lanes;
        logic [MAX_LANES-1:0][7:0] drv;
        logic [SMW-1:0]            same;
        logic [EQW-1:0]            eqn;
        logic                      ok;
        logic                      dn;
        logic                      fl;
    } ctl_t;

    ctl_t q, n;

    logic [MAX_LANES-1:0]       lane_en;
    logic [MAX_LANES-1:0][7:0]  adj_set;
    logic [MAX_LANES-1:0][1:0]  adj_sw;
    logic [MAX_LANES-1:0][7:0]  drv_new;
    logic                       cr_all, eq_all;
    logic                       at_top_swing, swing_repeat;
    logic                       xfer, tmr_zero, tmr_load;
    logic [LCW-1:0]             lane_clamp;

    function automatic logic is_access(input ltc_state_e s);
        return (s == S_CFG) || (s == S_TP1) || (s == S_CR_POLL) || (s == S_CR_ADJ) ||
               (s == S_TP3) || (s == S_EQ_POLL) || (s == S_EQ_ADJ) || (s == S_END);
    endfunction

    function automatic logic is_wait(input ltc_state_e s);
        return (s == S_CR_WAIT) || (s == S_EQ_WAIT);
    endfunction

    ltc_status_eval #(.MAX_LANES(MAX_LANES), .DW(DW)) u_eval (
        .rdata   (bus_rdata),
        .lane_en (lane_en),
        .cr_all  (cr_all),
        .eq_all  (eq_all)
    );

    ltc_lane_drive #(.MAX_LANES(MAX_LANES), .DW(DW)) u_drive (
        .rdata     (bus_rdata),
        .req_set   (adj_set),
        .req_swing (adj_sw)
    );

    ltc_delay #(.W(WAIT_W)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .span  (wait_cycles),
        .zero  (tmr_zero)
    );

    // lane helpers
    always_comb begin
        if (lane_sel == '0)
            lane_clamp = LCW'(1);
        else if (lane_sel > LCW'(MAX_LANES))
            lane_clamp = LCW'(MAX_LANES);
        else
            lane_clamp = lane_sel;

        at_top_swing = 1'b0;
        swing_repeat = 1'b1;
        for (int i = 0; i < MAX_LANES; i++) begin
            lane_en[i] = (LCW'(i) < q.lanes);
            drv_new[i] = lane_en[i] ? adj_set[i] : 8'h00;
            if (lane_en[i] && q.drv[i][1:0] == LVL_TOP)
                at_top_swing = 1'b1;
            if (lane_en[i] && adj_sw[i] != q.drv[i][1:0])
                swing_repeat = 1'b0;
        end
    end

    assign xfer = q.req & bus_done;

    // next-state logic
    always_comb begin
        n    = q;
        n.dn = 1'b0;
        n.fl = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    n.rate  = high_rate ? RATE_HI : RATE_LO;
                    n.lanes = lane_clamp;
                    n.drv   = '0;
                    n.same  = '0;
                    n.eqn   = '0;
                    n.ok    = 1'b0;
                    n.st    = S_CFG;
                end
            end
            S_CFG:     if (xfer) n.st = S_TP1;
            S_TP1:     if (xfer) n.st = S_CR_WAIT;
            S_CR_WAIT: if (tmr_zero) n.st = S_CR_POLL;
            S_CR_POLL: begin
                if (xfer) begin
                    if (cr_all) begin
                        n.st = S_TP3;
                    end else if (at_top_swing) begin
                        n.st = S_FALL;
                    end else if (swing_repeat && (q.same == SMW'(CR_SAME_MAX - 1))) begin
                        n.st = S_FALL;
                    end else begin
                        n.same = swing_repeat ? q.same + 1'b1 : '0;
                        n.drv  = drv_new;
                        n.st   = S_CR_ADJ;
                    end
                end
            end
            S_CR_ADJ:  if (xfer) n.st = S_CR_WAIT;
            S_TP3:     if (xfer) n.st = S_EQ_WAIT;
            S_EQ_WAIT: if (tmr_zero) n.st = S_EQ_POLL;
            S_EQ_POLL: begin
                if (xfer) begin
                    if (eq_all) begin
                        n.ok = 1'b1;
                        n.st = S_END;
                    end else if (!cr_all) begin
                        n.st = S_FALL;
                    end else if (q.eqn == EQW'(EQ_LOOPS)) begin
                        n.st = S_FALL;
                    end else begin
                        n.eqn = q.eqn + 1'b1;
                        n.drv = drv_new;
                        n.st  = S_EQ_ADJ;
                    end
                end
            end
            S_EQ_ADJ:  if (xfer) n.st = S_EQ_WAIT;
            S_FALL: begin
                if (q.rate == RATE_HI) begin
                    n.rate = RATE_LO;
                    n.drv  = '0;
                    n.same = '0;
                    n.eqn  = '0;
                    n.st   = S_CFG;
                end else begin
                    n.ok = 1'b0;
                    n.st = S_END;
                end
            end
            S_END: begin
                if (xfer) begin
                    n.dn = q.ok;
                    n.fl = ~q.ok;
                    n.st = S_IDLE;
                end
            end
            default: n.st = S_IDLE;
        endcase
        n.req = is_access(n.st) && !xfer;
    end

    assign tmr_load = is_wait(n.st) && !is_wait(q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    // access encoding
    always_comb begin
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_len   = '0;
        bus_wdata = '0;
        case (q.st)
            S_CFG: begin
                bus_wr         = 1'b1;
                bus_addr       = ADDR_W'(A_LINKCFG);
                bus_len        = 3'd2;
                bus_wdata[7:0] = q.rate;
                bus_wdata[15:8] = 8'h80 | 8'(q.lanes);
            end
            S_TP1, S_TP3: begin
                bus_wr         = 1'b1;
                bus_addr       = ADDR_W'(A_PATTERN);
                bus_len        = 3'(q.lanes) + 3'd1;
                bus_wdata[7:0] = (q.st == S_TP1) ? PAT_CR : PAT_EQ;
                for (int i = 0; i < MAX_LANES; i++)
                    if (lane_en[i]) bus_wdata[8*(i+1) +: 8] = q.drv[i];
            end
            S_CR_ADJ, S_EQ_ADJ: begin
                bus_wr   = 1'b1;
                bus_addr = ADDR_W'(A_DRIVE);
                bus_len  = 3'(q.lanes);
                for (int i = 0; i < MAX_LANES; i++)
                    if (lane_en[i]) bus_wdata[8*i +: 8] = q.drv[i];
            end
            S_CR_POLL, S_EQ_POLL: begin
                bus_addr = ADDR_W'(A_STATUS);
                bus_len  = 3'(POLL_LEN);
            end
            S_END: begin
                bus_wr         = 1'b1;
                bus_addr       = ADDR_W'(A_PATTERN);
                bus_len        = 3'd1;
                bus_wdata[7:0] = PAT_OFF;
            end
            default: ;
        endcase
    end

    assign bus_req    = q.req;
    assign train_done = q.dn;
    assign train_fail = q.fl;
    assign link_rate  = q.rate;
    assign link_lanes = q.lanes;

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(train_done && train_fail));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_done |=> !train_done);

    // R3
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_len)));

    // R1
    rate_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (link_rate == RATE_HI || link_rate == RATE_LO));

    // R8
    eq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.eqn <= EQW'(EQ_LOOPS));

    // R10
    same_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.same < SMW'(CR_SAME_MAX));

    // R6
    max_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && bus_addr == ADDR_W'(A_DRIVE)) |->
        (((bus_wdata[1:0] == LVL_TOP) == bus_wdata[2]) &&
         ((bus_wdata[4:3] == LVL_TOP) == bus_wdata[5])));

    // R11
    fall_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FALL && link_rate == RATE_HI) |=> (link_rate == RATE_LO && q.drv == '0));

endmodule

// File: tb/link_train_ctrl_test.sv
module link_train_ctrl_test;

    localparam int WAITV = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        high_rate = 1'b0;
    logic [1:0]  lane_sel = 2'd1;
    logic [15:0] wait_cycles = 16'(WAITV);
    logic        bus_req, bus_wr;
    logic [11:0] bus_addr;
    logic [2:0]  bus_len;
    logic [47:0] bus_wdata;
    logic        bus_done = 1'b0;
    logic [47:0] bus_rdata = '0;
    logic        train_done, train_fail;
    logic [7:0]  link_rate;
    logic [1:0]  link_lanes;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [11:0] wl_addr [64];
    logic [2:0]  wl_len  [64];
    logic [47:0] wl_data [64];
    logic [47:0] resp    [64];
    int wc = 0, rc = 0, rp = 0;
    int last_wr = 0, min_gap = 1000000;

    link_train_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .high_rate(high_rate),
        .lane_sel(lane_sel), .wait_cycles(wait_cycles),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .train_done(train_done), .train_fail(train_fail),
        .link_rate(link_rate), .link_lanes(link_lanes)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // sink model
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req && !bus_done) begin
                if (!bus_wr && bus_addr == 12'h202 && (cyc - last_wr) < min_gap)
                    min_gap = cyc - last_wr;
                @(negedge clk);
                if (bus_wr) begin
                    if (wc < 64) begin
                        wl_addr[wc] = bus_addr;
                        wl_len[wc]  = bus_len;
                        wl_data[wc] = bus_wdata;
                    end
                    wc++;
                    last_wr = cyc;
                end else begin
                    bus_rdata = (rp < 64) ? resp[rp] : 48'h0;
                    rp++;
                    rc++;
                end
                bus_done = 1'b1;
                @(negedge clk);
                bus_done  = 1'b0;
                bus_rdata = '0;
            end
        end
    end

    function automatic logic [47:0] mk(input logic [7:0] s, input logic [7:0] b2, input logic [7:0] adj);
        return {8'h00, adj, 8'h00, b2, 8'h00, s};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exp_wr(input string tag, input int idx, input logic [11:0] a,
                          input logic [2:0] l, input logic [47:0] d);
        logic [47:0] m;
        m = (48'h1 << (8 * l)) - 48'h1;
        if (idx >= wc)
            chk(tag, 64'(wc), 64'(idx + 1));
        else
            chk(tag, {1'b0, wl_addr[idx], wl_len[idx], wl_data[idx] & m}, {1'b0, a, l, d & m});
    endtask

    task automatic run_train(input logic hi, input logic [1:0] ls, output logic got_dn, output logic got_fl);
        wc = 0; rc = 0; rp = 0;
        got_dn = 1'b0; got_fl = 1'b0;
        @(negedge clk);
        high_rate = hi; lane_sel = ls; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (train_done || train_fail) begin
                got_dn = train_done; got_fl = train_fail;
                break;
            end
        end
        @(negedge clk);
        chk("R12 pulse one cycle", {62'd0, train_done, train_fail}, 64'd0);
    endtask

    task automatic t_reset;
        chk("R12 reset req",   64'(bus_req), 64'd0);
        chk("R12 reset pulse", {62'd0, train_done, train_fail}, 64'd0);
        chk("R12 reset rate",  64'(link_rate), 64'd0);
    endtask

    task automatic t_one_lane;
        logic d, f;
        resp[0] = mk(8'h01, 8'h80, 8'h00);
        resp[1] = mk(8'h07, 8'h81, 8'h00);
        run_train(1'b0, 2'd1, d, f);
        chk("R7 pass one lane", {62'd0, d, f}, 64'd2);
        exp_wr("R1 cfg one lane", 0, 12'h100, 3'd2, 48'h8106);
        exp_wr("R2 tp1 one lane", 1, 12'h102, 3'd2, 48'h0021);
        exp_wr("R4 tp3 one lane", 2, 12'h102, 3'd2, 48'h0023);
        exp_wr("R7 end write",    3, 12'h102, 3'd1, 48'h00);
        chk("R3 poll count", 64'(rc), 64'd2);
        chk("R12 held rate/lanes", {54'd0, link_rate, link_lanes}, {54'd0, 8'h06, 2'd1});
    endtask

    task automatic t_two_lane_adjust;
        logic d, f;
        resp[0] = mk(8'h00, 8'h80, 8'h11);
        resp[1] = mk(8'h11, 8'h80, 8'h00);
        resp[2] = mk(8'h77, 8'h80, 8'h44);
        resp[3] = mk(8'h77, 8'h81, 8'h00);
        run_train(1'b0, 2'd2, d, f);
        chk("R7 pass two lanes", {62'd0, d, f}, 64'd2);
        exp_wr("R1 cfg two lanes", 0, 12'h100, 3'd2, 48'h8206);
        exp_wr("R2 tp1 two lanes", 1, 12'h102, 3'd3, 48'h000021);
        exp_wr("R5 cr adjust",     2, 12'h103, 3'd2, 48'h0101);
        exp_wr("R4 tp3 settings",  3, 12'h102, 3'd3, 48'h010123);
        exp_wr("R7 no align retry R5 0x44", 4, 12'h103, 3'd2, 48'h0808);
        exp_wr("R7 end two lanes", 5, 12'h102, 3'd1, 48'h00);
    endtask

    task automatic t_max_flags;
        logic d, f;
        resp[0] = mk(8'h00, 8'h80, 8'hCF);
        resp[1] = mk(8'h11, 8'h80, 8'h00);
        resp[2] = mk(8'h77, 8'h81, 8'h00);
        run_train(1'b0, 2'd2, d, f);
        exp_wr("R6 max flags",            2, 12'h103, 3'd2, 48'h383F);
        exp_wr("R13 cr pass at swing 3",  3, 12'h102, 3'd3, 48'h383F23);
        chk("R13 pass at top swing", {62'd0, d, f}, 64'd2);
    endtask

    task automatic t_eq_limit(input logic last_ok);
        logic d, f;
        resp[0] = mk(8'h11, 8'h80, 8'h00);
        for (int k = 1; k <= 5; k++) resp[k] = mk(8'h11, 8'h80, 8'h44);
        resp[6] = last_ok ? mk(8'h77, 8'h81, 8'h44) : mk(8'h11, 8'h80, 8'h44);
        resp[7] = mk(8'h11, 8'h80, 8'h00);
        resp[8] = mk(8'h77, 8'h81, 8'h00);
        run_train(1'b1, 2'd2, d, f);
        chk("R8 pass after limit", {62'd0, d, f}, 64'd2);
        exp_wr("R1 cfg high rate", 0, 12'h100, 3'd2, 48'h820A);
        for (int k = 3; k <= 7; k++) exp_wr("R8 eq adjust", k, 12'h103, 3'd2, 48'h0808);
        if (last_ok) begin
            exp_wr("R13 end beats limit", 8, 12'h102, 3'd1, 48'h00);
            chk("R13 rate kept", 64'(link_rate), 64'h0A);
            chk("R13 write count", 64'(wc), 64'd9);
        end else begin
            exp_wr("R11 cfg fallback", 8, 12'h100, 3'd2, 48'h8206);
            exp_wr("R11 drive zeroed", 9, 12'h102, 3'd3, 48'h000021);
            chk("R11 final rate", 64'(link_rate), 64'h06);
            chk("R8 poll count", 64'(rc), 64'd9);
        end
    endtask

    task automatic t_cr_repeat_fail;
        logic d, f;
        for (int k = 0; k < 5; k++) resp[k] = mk(8'h00, 8'h80, 8'h00);
        run_train(1'b0, 2'd1, d, f);
        chk("R11 fail at low rate", {62'd0, d, f}, 64'd1);
        for (int k = 2; k <= 5; k++) exp_wr("R10 repeat adjust", k, 12'h103, 3'd1, 48'h00);
        exp_wr("R11 end after fail", 6, 12'h102, 3'd1, 48'h00);
        chk("R10 write count", 64'(wc), 64'd7);
        chk("R12 rate held after fail", 64'(link_rate), 64'h06);
    endtask

    task automatic t_cr_top_swing;
        logic d, f;
        resp[0] = mk(8'h00, 8'h80, 8'h33);
        resp[1] = mk(8'h00, 8'h80, 8'h33);
        resp[2] = mk(8'h11, 8'h80, 8'h00);
        resp[3] = mk(8'h77, 8'h81, 8'h00);
        run_train(1'b1, 2'd2, d, f);
        exp_wr("R6 swing 3 flag",       2, 12'h103, 3'd2, 48'h0707);
        exp_wr("R10 fallback at top",   3, 12'h100, 3'd2, 48'h8206);
        chk("R10 pass lower rate", {54'd0, d, f, link_rate}, {54'd0, 2'd2, 8'h06});
    endtask

    task automatic t_lost_cr;
        logic d, f;
        resp[0] = mk(8'h11, 8'h80, 8'h00);
        resp[1] = mk(8'h10, 8'h80, 8'h00);
        resp[2] = mk(8'h11, 8'h80, 8'h00);
        resp[3] = mk(8'h77, 8'h81, 8'h00);
        run_train(1'b1, 2'd3, d, f);
        exp_wr("R1 lane clamp", 0, 12'h100, 3'd2, 48'h820A);
        exp_wr("R9 fallback on lost lock", 3, 12'h100, 3'd2, 48'h8206);
        chk("R9 pass after fallback", {62'd0, d, f}, 64'd2);
    endtask

    task automatic t_zero_lanes;
        logic d, f;
        resp[0] = mk(8'h01, 8'h80, 8'h00);
        resp[1] = mk(8'h07, 8'h81, 8'h00);
        run_train(1'b0, 2'd0, d, f);
        exp_wr("R1 zero lanes means one", 0, 12'h100, 3'd2, 48'h8106);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_one_lane;
        t_two_lane_adjust;
        t_max_flags;
        t_eq_limit(1'b0);
        t_eq_limit(1'b1);
        t_cr_repeat_fail;
        t_cr_top_swing;
        t_lost_cr;
        t_zero_lanes;
        total++;
        if (min_gap < WAITV) begin
            bad++;
            $display("FAIL R14 wait gap actual=%0d expected>=%0d", min_gap, WAITV);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule